// File: doc/BRIEF.md
# I2C Register Slave with Change Interrupt

This block is a serial-bus target that sits between a host controller and a touch-sensing core. The host reaches a 64-byte register space through one internal memory pointer. The first byte of a write transfer sets that pointer, and later bytes in the same transfer land at successive addresses. A read transfer streams bytes out from the pointer until the host declines with a NACK. The block sends no address of its own on a read. At every START and STOP, and after a bus recovery, the pointer returns to the last address the host wrote, so the host can poll one location again and again without re-addressing it. Pointer arithmetic is modulo 64.

The block watches two live status bytes from the sensing core: key detection and input-pin levels. A change in any watched bit pulls an active-low, open-drain change line. A per-bit key mask, held in the configuration space, selects which detection bits are watched. The change line is released when the host reads the input-status byte. If the watched bits have already returned to the values seen at the previous status read, a read of any address also releases it.

Writing a nonzero value to either of two command addresses produces a one-cycle strobe toward the core. A watchdog returns the bus logic to idle when either bus line sits low with no edge on either line for a set number of system clocks. The watchdog is off while the standalone input is high. SCL and SDA are sampled and edge-detected on a system clock that runs at least 16 times the bus bit rate. The block does not stretch the clock.

Top module: `chg_i2c_regslave`

## Requirements
- R1: The block acknowledges, by pulling SDA low during the ninth clock, only an address byte whose upper seven bits equal 0x12. Any other address gets no acknowledge, and the block stays off the bus until the next START.
- R2: In a write transfer, the first data byte loads the pointer (lower six bits). Each later byte is stored at the pointer, which then increments. Every data byte is acknowledged.
- R3: In a read transfer (address byte bit 0 = 1), the block sends the byte at the pointer MSB first and increments the pointer after each byte. It continues while the host acknowledges and stops after a host NACK.
- R4: At START, at STOP and after a watchdog recovery, the pointer returns to the value most recently loaded by a write transfer.
- R5: A nonzero byte written to address 12 gives a one-cycle pulse on `cal_stb`. A nonzero byte written to address 13 gives a one-cycle pulse on `rst_stb`. Writing zero to either address gives no pulse.
- R6: Address 0 reads 0x31. Address 1 reads 0x03. Address 4 reads the detection status with bit 6 forced to 0. Address 5 reads the input status in bits 6..0 with bit 7 at 0. Addresses outside the identity, status and configuration ranges read 0.
- R7: The change line is asserted within a few system clocks of a change in a watched bit. Watched bits are: detection bits 0..5 whose key-mask bit is 1, detection bit 7 when key-mask bit 7 is 1, and all seven input-status bits. Detection bit 6 is never watched.
- R8: The change line is released when a byte read from address 5 is completed, i.e. when the host's acknowledge bit for that byte is sampled. A completed read of any other address releases it only if the watched bits equal their values at the last address-5 read.
- R9: When either bus line is low and neither line has an edge for WDOG_CYCLES system clocks, the bus logic returns to idle and releases SDA. When `standalone` is high, this timeout never fires.
- R10: Configuration bytes 14..31 reset to 0, except the key mask at address 24, which resets to 0xBF. Each of these bytes is writable and appears on `cfg_flat` with address 14 in bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standalone | input | 1 | High disables the bus watchdog |
| scl_in | input | 1 | Sampled level of the bus clock line |
| sda_in | input | 1 | Sampled level of the bus data line |
| det_status | input | 8 | Live key detection byte; bit 7 is the calibrating flag |
| in_status | input | 7 | Live input-pin levels |
| sda_pd | output | 1 | High pulls SDA low |
| chg_pd | output | 1 | High pulls the change line low |
| cfg_flat | output | CFG_COUNT*8 | Configuration bytes, lowest address in the low byte |
| key_mask | output | 8 | Current key mask byte |
| cal_stb | output | 1 | One-cycle calibrate command |
| rst_stb | output | 1 | One-cycle reset command |

## Verification
A pointer that fails to rewind, or that increments at the wrong moment, shows up on the first byte of the next read transfer: data appears from a different address, one bus byte time (about 9 SCL periods) after the address acknowledge. A wrong change-detection reference leaves the change line stuck low, or releases it early, on the first completed read after a status change. The sweep over mask values and status bits shows this at `chg_pd` a few system clocks after the stimulus. A bus state machine left in a non-idle state appears either as a missing acknowledge on the following transfer or as SDA held low past the watchdog window.

// File: rtl/rs_pkg.sv
package rs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_RACK
   } bus_st_t;

   localparam int unsigned MAP_AW = 6;

   localparam logic [MAP_AW-1:0] A_ID  = 6'd0;
   localparam logic [MAP_AW-1:0] A_VER = 6'd1;
   localparam logic [MAP_AW-1:0] A_DET = 6'd4;
   localparam logic [MAP_AW-1:0] A_INP = 6'd5;
   localparam logic [MAP_AW-1:0] A_CAL = 6'd12;
   localparam logic [MAP_AW-1:0] A_RST = 6'd13;
endpackage

// File: rtl/rs_line_sync.sv
module rs_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic level,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rs_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         last  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], line_in};
         last  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = level & ~last;
   assign fall  = ~level & last;
endmodule

// File: rtl/rs_wdog.sv
module rs_wdog #(
   parameter int TIMEOUT = 1750000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic scl,
   input  logic sda,
   input  logic activity,
   output logic bus_clr
);
   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("rs_wdog: TIMEOUT must be at least 2");
   end

   localparam int CW = $clog2(TIMEOUT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         bus_clr <= 1'b0;
      end else begin
         bus_clr <= 1'b0;
         if (!enable || activity || (scl && sda)) begin
            cnt <= '0;
         end else if (cnt == CW'(TIMEOUT - 1)) begin
            cnt     <= '0;
            bus_clr <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assert_wdog_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !bus_clr);
   assert_wdog_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_clr |-> $past(!scl || !sda));
endmodule

// File: rtl/rs_bus_engine.sv
module rs_bus_engine
   import rs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl,
   input  logic              sda,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_rise,
   input  logic              sda_fall,
   input  logic              bus_clr,
   input  logic [7:0]        rd_byte,
   output logic [MAP_AW-1:0] ptr,
   output logic              wr_stb,
   output logic [MAP_AW-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              rd_stb,
   output logic [MAP_AW-1:0] rd_addr,
   output logic              sda_pd
);
   bus_st_t           state;
   logic [3:0]        cnt;
   logic [7:0]        shreg;
   logic [MAP_AW-1:0] base;
   logic              first;
   logic              rw;
   logic              acked;
   logic              start;
   logic              stop;

   assign start = sda_fall & scl;
   assign stop  = sda_rise & scl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         ptr     <= '0;
         base    <= '0;
         first   <= 1'b0;
         rw      <= 1'b0;
         acked   <= 1'b0;
         sda_pd  <= 1'b0;
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         rd_stb  <= 1'b0;
         rd_addr <= '0;
      end else begin
         wr_stb <= 1'b0;
         rd_stb <= 1'b0;
         if (bus_clr || stop) begin
            state  <= ST_IDLE;
            sda_pd <= 1'b0;
            ptr    <= base;
         end else if (start) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_pd <= 1'b0;
            ptr    <= base;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg <= {shreg[6:0], sda};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     if (shreg[7:1] == DEV_ADDR) begin
                        sda_pd <= 1'b1;
                        rw     <= shreg[0];
                        state  <= ST_AACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        shreg  <= rd_byte;
                        sda_pd <= ~rd_byte[7];
                        state  <= ST_RD;
                     end else begin
                        sda_pd <= 1'b0;
                        first  <= 1'b1;
                        state  <= ST_WR;
                     end
                  end
               end
               ST_WR: begin
                  if (scl_rise) begin
                     shreg <= {shreg[6:0], sda};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     sda_pd <= 1'b1;
                     state  <= ST_WACK;
                     if (first) begin
                        ptr   <= shreg[MAP_AW-1:0];
                        base  <= shreg[MAP_AW-1:0];
                        first <= 1'b0;
                     end else begin
                        wr_stb  <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= shreg;
                        ptr     <= ptr + 1'b1;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     sda_pd <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_pd <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_pd <= ~shreg[6];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     acked   <= ~sda;
                     rd_stb  <= 1'b1;
                     rd_addr <= ptr;
                     ptr     <= ptr + 1'b1;
                  end else if (scl_fall) begin
                     if (acked) begin
                        cnt    <= '0;
                        shreg  <= rd_byte;
                        sda_pd <= ~rd_byte[7];
                        state  <= ST_RD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end

   // R1: no drive on the data line while not addressed
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_pd);
   // R4: the pointer returns to the host-written base at bus framing events
   assert_ptr_rewind_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop || bus_clr) |=> (ptr == $past(base)));
   assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   assert_rd_in_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> $past(state) == ST_RACK);
endmodule

// File: rtl/rs_regmap.sv
module rs_regmap
   import rs_pkg::*;
#(
   parameter int         CFG_BASE      = 14,
   parameter int         CFG_COUNT     = 18,
   parameter int         KEYMASK_ADDR  = 24,
   parameter logic [7:0] KEYMASK_RESET = 8'hBF,
   parameter logic [3:0] MAJOR_ID      = 4'd3,
   parameter logic [3:0] MINOR_ID      = 4'd1,
   parameter logic [7:0] VERSION       = 8'h03
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [MAP_AW-1:0]      ptr,
   input  logic [7:0]             det_status,
   input  logic [6:0]             in_status,
   input  logic                   wr_stb,
   input  logic [MAP_AW-1:0]      wr_addr,
   input  logic [7:0]             wr_data,
   input  logic                   rd_stb,
   input  logic [MAP_AW-1:0]      rd_addr,
   output logic [7:0]             rd_byte,
   output logic [CFG_COUNT*8-1:0] cfg_flat,
   output logic [7:0]             key_mask,
   output logic                   cal_stb,
   output logic                   rst_stb,
   output logic                   chg_pd
);
   localparam int KM_IDX = KEYMASK_ADDR - CFG_BASE;
   localparam int WW     = 15;
   localparam logic [7:0] ID_BYTE = {MAJOR_ID, MINOR_ID};

   if (CFG_BASE <= int'(A_RST) || CFG_BASE + CFG_COUNT > (1 << MAP_AW)) begin : g_bad_range
      $error("rs_regmap: configuration range overlaps fixed addresses or exceeds the map");
   end
   if (KM_IDX < 0 || KM_IDX >= CFG_COUNT) begin : g_bad_keymask
      $error("rs_regmap: key mask address outside configuration range");
   end

   logic [CFG_COUNT-1:0][7:0] cfg_q;

   function automatic logic [7:0] reset_value(input int idx);
      return (CFG_BASE + idx == KEYMASK_ADDR) ? KEYMASK_RESET : 8'h00;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CFG_COUNT; i++) cfg_q[i] <= reset_value(i);
      end else if (wr_stb) begin
         for (int i = 0; i < CFG_COUNT; i++) begin
            if (wr_addr == MAP_AW'(CFG_BASE + i)) cfg_q[i] <= wr_data;
         end
      end
   end

   for (genvar g = 0; g < CFG_COUNT; g++) begin : g_cfg_out
      assign cfg_flat[g*8 +: 8] = cfg_q[g];
   end
   assign key_mask = cfg_q[KM_IDX];

   always_comb begin
      rd_byte = 8'h00;
      if (ptr == A_ID)       rd_byte = ID_BYTE;
      else if (ptr == A_VER) rd_byte = VERSION;
      else if (ptr == A_DET) rd_byte = det_status & 8'hBF;
      else if (ptr == A_INP) rd_byte = {1'b0, in_status};
      for (int i = 0; i < CFG_COUNT; i++) begin
         if (ptr == MAP_AW'(CFG_BASE + i)) rd_byte = cfg_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_stb <= 1'b0;
         rst_stb <= 1'b0;
      end else begin
         cal_stb <= wr_stb && (wr_addr == A_CAL) && (wr_data != 8'h00);
         rst_stb <= wr_stb && (wr_addr == A_RST) && (wr_data != 8'h00);
      end
   end

   logic [WW-1:0] watched;
   logic [WW-1:0] prev_w;
   logic [WW-1:0] ref_w;
   logic          armed;

   assign watched = {in_status, det_status & key_mask & 8'hBF};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_w <= '0;
         ref_w  <= '0;
         armed  <= 1'b0;
         chg_pd <= 1'b0;
      end else begin
         prev_w <= watched;
         armed  <= 1'b1;
         if (!armed || (rd_stb && rd_addr == A_INP)) ref_w <= watched;
         if (armed && watched != prev_w) begin
            chg_pd <= 1'b1;
         end else if (rd_stb && (rd_addr == A_INP || watched == ref_w)) begin
            chg_pd <= 1'b0;
         end
      end
   end

   assert_cal_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cal_stb |=> !cal_stb);
   assert_cal_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_stb || rst_stb) |-> ($past(wr_stb) && $past(wr_data) != 8'h00));
   assert_chg_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chg_pd) |-> $past(rd_stb));
   assert_chg_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cal_stb, rst_stb}));
endmodule

// File: rtl/chg_i2c_regslave.sv
module chg_i2c_regslave
   import rs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR      = 7'h12,
   parameter int         SYNC_STAGES   = 2,
   parameter int         WDOG_CYCLES   = 1750000,
   parameter int         CFG_BASE      = 14,
   parameter int         CFG_COUNT     = 18,
   parameter int         KEYMASK_ADDR  = 24,
   parameter logic [7:0] KEYMASK_RESET = 8'hBF,
   parameter logic [7:0] VERSION       = 8'h03
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   standalone,
   input  logic                   scl_in,
   input  logic                   sda_in,
   input  logic [7:0]             det_status,
   input  logic [6:0]             in_status,
   output logic                   sda_pd,
   output logic                   chg_pd,
   output logic [CFG_COUNT*8-1:0] cfg_flat,
   output logic [7:0]             key_mask,
   output logic                   cal_stb,
   output logic                   rst_stb
);
   logic              scl, scl_rise, scl_fall;
   logic              sda, sda_rise, sda_fall;
   logic              bus_clr;
   logic [MAP_AW-1:0] ptr, wr_addr, rd_addr;
   logic [7:0]        wr_data, rd_byte;
   logic              wr_stb, rd_stb;

   rs_line_sync #(.STAGES(SYNC_STAGES)) i_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_in(scl_in),
      .level(scl), .rise(scl_rise), .fall(scl_fall));

   rs_line_sync #(.STAGES(SYNC_STAGES)) i_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_in(sda_in),
      .level(sda), .rise(sda_rise), .fall(sda_fall));

   rs_wdog #(.TIMEOUT(WDOG_CYCLES)) i_wdog (
      .clk(clk), .rst_n(rst_n), .enable(!standalone),
      .scl(scl), .sda(sda),
      .activity(scl_rise | scl_fall | sda_rise | sda_fall),
      .bus_clr(bus_clr));

   rs_bus_engine #(.DEV_ADDR(DEV_ADDR)) i_engine (
      .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_rise(sda_rise), .sda_fall(sda_fall),
      .bus_clr(bus_clr), .rd_byte(rd_byte), .ptr(ptr),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_stb(rd_stb), .rd_addr(rd_addr), .sda_pd(sda_pd));

   rs_regmap #(
      .CFG_BASE(CFG_BASE), .CFG_COUNT(CFG_COUNT),
      .KEYMASK_ADDR(KEYMASK_ADDR), .KEYMASK_RESET(KEYMASK_RESET),
      .VERSION(VERSION)
   ) i_regmap (
      .clk(clk), .rst_n(rst_n), .ptr(ptr),
      .det_status(det_status), .in_status(in_status),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_byte(rd_byte),
      .cfg_flat(cfg_flat), .key_mask(key_mask),
      .cal_stb(cal_stb), .rst_stb(rst_stb), .chg_pd(chg_pd));
endmodule

// File: tb/test_chg_i2c_regslave.sv
`timescale 1ns/1ps
module test_chg_i2c_regslave;
   localparam int Q     = 10;
   localparam int WDOG  = 600;
   localparam int NCFG  = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic standalone = 1'b0;
   logic host_scl = 1'b1;
   logic host_sda = 1'b1;
   logic [7:0] det = 8'h00;
   logic [6:0] inp = 7'h00;
   logic sda_pd, chg_pd, cal_stb, rst_stb;
   logic [NCFG*8-1:0] cfg_flat;
   logic [7:0] key_mask;
   logic bus_sda;

   int n_chk = 0;
   int n_fail = 0;
   int cal_cnt = 0, rst_cnt = 0, wide_cnt = 0;
   logic cal_prev = 1'b0, rst_prev = 1'b0;
   bit done = 0;

   always #4 clk = ~clk;

   assign bus_sda = host_sda & ~sda_pd;

   chg_i2c_regslave #(.WDOG_CYCLES(WDOG)) i_chg_i2c_regslave (
      .clk(clk), .rst_n(rst_n), .standalone(standalone),
      .scl_in(host_scl), .sda_in(bus_sda),
      .det_status(det), .in_status(inp),
      .sda_pd(sda_pd), .chg_pd(chg_pd), .cfg_flat(cfg_flat),
      .key_mask(key_mask), .cal_stb(cal_stb), .rst_stb(rst_stb));

   always @(posedge clk) begin
      if (rst_n) begin
         if (cal_stb) cal_cnt++;
         if (rst_stb) rst_cnt++;
         if ((cal_stb && cal_prev) || (rst_stb && rst_prev)) wide_cnt++;
      end
      cal_prev <= cal_stb;
      rst_prev <= rst_stb;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      host_sda = 1'b1; host_scl = 1'b1; tick(Q);
      host_sda = 1'b0; tick(Q);
      host_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      host_sda = 1'b0; tick(Q);
      host_scl = 1'b1; tick(Q);
      host_sda = 1'b1; tick(2*Q);
   endtask

   task automatic put_bit(input logic b);
      host_sda = b; tick(Q);
      host_scl = 1'b1; tick(2*Q);
      host_scl = 1'b0; tick(Q);
   endtask

   task automatic get_bit(output logic b);
      host_sda = 1'b1; tick(Q);
      host_scl = 1'b1; tick(Q);
      b = bus_sda; tick(Q);
      host_scl = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(input logic last, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(last);
      host_sda = 1'b1;
   endtask

   task automatic set_reg(input logic [7:0] a, input logic [7:0] d);
      logic ack;
      bus_start();
      send_byte(8'h24, ack); check("R1 address ack", ack, 1);
      send_byte(a, ack);     check("R2 pointer ack", ack, 1);
      send_byte(d, ack);     check("R2 data ack", ack, 1);
      bus_stop();
   endtask

   task automatic set_ptr(input logic [7:0] a);
      logic ack;
      bus_start();
      send_byte(8'h24, ack); check("R1 address ack", ack, 1);
      send_byte(a, ack);     check("R2 pointer ack", ack, 1);
      bus_stop();
   endtask

   task automatic read_one(output logic [7:0] v);
      logic ack;
      bus_start();
      send_byte(8'h25, ack); check("R1 read address ack", ack, 1);
      recv_byte(1'b1, v);
      bus_stop();
   endtask

   task automatic read_burst(input int n, output logic [7:0] v [8]);
      logic ack;
      bus_start();
      send_byte(8'h25, ack); check("R1 read address ack", ack, 1);
      for (int i = 0; i < n; i++) recv_byte(i == n - 1, v[i]);
      bus_stop();
   endtask

   function automatic logic [7:0] cfg_at(input int a);
      return cfg_flat[(a-14)*8 +: 8];
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] v [8];
      logic ack;
      logic [7:0] masks [5];
      masks[0] = 8'hBF; masks[1] = 8'h00; masks[2] = 8'hFF;
      masks[3] = 8'h5A; masks[4] = 8'hA5;

      tick(5);
      rst_n = 1'b1;
      tick(5);

      // Reset state (R10, R7)
      check("R7 chg after reset", chg_pd, 0);
      check("R1 sda idle after reset", sda_pd, 0);
      check("R10 key mask reset", cfg_at(24), 8'hBF);
      check("R10 key mask port", key_mask, 8'hBF);
      check("R10 other cfg reset", cfg_at(14), 8'h00);

      // R1: foreign addresses are not acknowledged
      bus_start(); send_byte(8'h26, ack); bus_stop();
      check("R1 no ack 0x13", ack, 0);
      bus_start(); send_byte(8'h52, ack); bus_stop();
      check("R1 no ack 0x29", ack, 0);

      // R6 / R3: identity and status burst
      det = 8'hC5; inp = 7'h2A;
      set_ptr(8'h00);
      read_burst(6, v);
      check("R6 addr0", v[0], 8'h31);
      check("R6 addr1", v[1], 8'h03);
      check("R6 addr2", v[2], 8'h00);
      check("R6 addr3", v[3], 8'h00);
      check("R6 addr4 det", v[4], 8'h85);
      check("R6 addr5 inp", v[5], 8'h2A);
      set_ptr(8'd40); read_one(d);
      check("R6 unmapped", d, 8'h00);
      set_ptr(8'd12); read_one(d);
      check("R6 command addr", d, 8'h00);
      det = 8'h00; inp = 7'h00;
      tick(4);

      // R2: multi-byte write
      bus_start();
      send_byte(8'h24, ack); send_byte(8'd14, ack);
      send_byte(8'hA1, ack); send_byte(8'hB2, ack); send_byte(8'hC3, ack);
      check("R2 last data ack", ack, 1);
      bus_stop();
      check("R2 cfg14", cfg_at(14), 8'hA1);
      check("R2 cfg15", cfg_at(15), 8'hB2);
      check("R2 cfg16", cfg_at(16), 8'hC3);
      check("R2 cfg17 untouched", cfg_at(17), 8'h00);

      // R3 / R4: burst readback from rewound pointer
      read_burst(3, v);
      check("R3 burst 0", v[0], 8'hA1);
      check("R3 burst 1", v[1], 8'hB2);
      check("R3 burst 2", v[2], 8'hC3);
      read_one(d);
      check("R4 rewind", d, 8'hA1);
      set_reg(8'd31, 8'h7E);
      check("R10 cfg31", cfg_at(31), 8'h7E);
      read_one(d);
      check("R4 rewind to 31", d, 8'h7E);

      // R5: command strobes
      set_reg(8'd12, 8'h01);
      check("R5 cal pulse", cal_cnt, 1);
      set_reg(8'd12, 8'h00);
      check("R5 cal zero ignored", cal_cnt, 1);
      set_reg(8'd13, 8'h80);
      check("R5 rst pulse", rst_cnt, 1);
      set_reg(8'd13, 8'h00);
      check("R5 rst zero ignored", rst_cnt, 1);
      check("R5 cal no rst", cal_cnt, 1);
      check("R5 single cycle", wide_cnt, 0);

      // R7 sweep: detection bits against key masks
      foreach (masks[m]) begin
         set_reg(8'd24, masks[m]);
         set_ptr(8'd5); read_one(d);
         check("R8 clear by status read", chg_pd, 0);
         for (int k = 0; k < 8; k++) begin
            det[k] = 1'b1; tick(8);
            check($sformatf("R7 det bit %0d mask %0h", k, masks[m]), chg_pd,
                  (k != 6) && masks[m][k]);
            det[k] = 1'b0; tick(4);
            read_one(d);
            check("R8 status read releases", chg_pd, 0);
         end
      end
      set_reg(8'd24, 8'hBF);
      set_ptr(8'd5); read_one(d);
      // R7: input bits always watched
      for (int k = 0; k < 7; k++) begin
         inp[k] = 1'b1; tick(8);
         check($sformatf("R7 input bit %0d", k), chg_pd, 1);
         read_one(d);
         check("R8 input read clears", chg_pd, 0);
         check("R6 input readback", d, 8'(1 << k));
         inp[k] = 1'b0; tick(4);
         read_one(d);
      end

      // R8: other-address reads
      det[0] = 1'b1; tick(8);
      check("R7 set for R8", chg_pd, 1);
      set_ptr(8'd0); read_one(d);
      check("R8 other read keeps chg", chg_pd, 1);
      set_ptr(8'd4); read_burst(2, v);
      check("R8 burst 4-5 clears", chg_pd, 0);
      det[0] = 1'b0; tick(4); det[0] = 1'b1; tick(8);
      check("R8 returned change asserted", chg_pd, 1);
      set_ptr(8'd0); read_one(d);
      check("R8 any read clears when returned", chg_pd, 0);
      det[0] = 1'b0; tick(4);
      set_ptr(8'd5); read_one(d);

      // R9: watchdog with slave holding SDA low
      set_ptr(8'd0);
      bus_start(); send_byte(8'h25, ack);
      tick(20);
      check("R3 first bit driven", sda_pd, 1);
      tick(WDOG + 20);
      check("R9 watchdog releases sda", sda_pd, 0);
      bus_stop();
      standalone = 1'b1;
      bus_start(); send_byte(8'h25, ack);
      tick(WDOG + 20);
      check("R9 standalone holds", sda_pd, 1);
      standalone = 1'b0;
      tick(WDOG + 20);
      check("R9 re-enabled releases", sda_pd, 0);
      bus_stop();
      read_one(d);
      check("R4 pointer after recovery", d, 8'h31);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule